// File: doc/BRIEF.md
# Multi-Sector Flash Erase Sequencer

This engine erases a run of consecutive, equally sized sectors in a byte-wide parallel NOR flash. A single strobe on `start` delivers a byte start address and a sector count. The engine first checks the request. It then drives the six-write erase unlock preamble onto the flash bus and queues one sector-erase command per sector. Between sector commands it reads the status byte to confirm that the device is still accepting commands.

Once every sector is queued, the engine polls the status byte at the first sector. It keeps polling until the embedded erase finishes, stalls with a fault, or uses up the poll budget. It then pulses `done` for one cycle and holds a 3-bit result on `err` until the next accepted request.

The state machine has eight states:

- **IDLE** waits for `start`.
- **PREAMBLE** issues the six unlock writes, one per cycle.
- **SECTOR** writes the sector-erase command.
- **WIN_READ** and **WIN_WAIT** perform the status read between commands.
- **POLL_READ** and **POLL_WAIT** perform one completion poll read.
- **FINISH** pulses `done`.

It uses the following transitions:

- **IDLE→PREAMBLE** on a valid request.
- **IDLE→FINISH** on a rejected request.
- **PREAMBLE→SECTOR** after the sixth write.
- **SECTOR→SECTOR** after the first sector command when more sectors remain.
- **SECTOR→POLL_READ** when the first command was also the last.
- **SECTOR→WIN_READ** after every later command.
- **WIN_READ→WIN_WAIT** unconditionally.
- **WIN_WAIT→FINISH** when the window has closed.
- **WIN_WAIT→SECTOR** while sectors remain.
- **WIN_WAIT→POLL_READ** when none remain.
- **POLL_READ→POLL_WAIT** unconditionally.
- **POLL_WAIT→POLL_READ** while undecided.
- **POLL_WAIT→FINISH** on a verdict or an exhausted budget.
- **FINISH→IDLE** unconditionally.

Top module: `sector_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `fl_cs` are all 0.
- R2: A request is rejected with `err`=1 and a `done` pulse, and makes no bus access, in any of these cases:
  - the start address is not a multiple of 2^SECT_W bytes;
  - the count is zero;
  - the start sector plus the count exceeds 2^(ADDR_W-SECT_W).
  
  A request that ends exactly on the last sector is accepted.
- R3: An accepted request first writes, in this order: 0xF0 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA.
- R4: After the preamble, data 0x30 is written to the base address of each requested sector, in ascending sector order, once per sector.
- R5: After every sector command except the first, the status is read at that sector's address. If bit 3 is set, no further sector command is written, no poll read is made, and the request ends with `err`=2.
- R6: Completion polling reads the first sector's address. From the third poll read on, a read with bit 7 set ends the request with `err`=0.
- R7: From the third poll read on, a read whose bit 7 is low and which equals the previous read ends the request. It ends with `err`=3 when bit 5 of the read before that previous one is set.
- R8: In the same stalled case with that bit 5 clear, the request ends with `err`=4.
- R9: If no verdict has been reached by the POLL_LIMIT-th poll read, the request ends with `err`=5 after exactly POLL_LIMIT poll reads. A completion seen on that final read still gives `err`=0.
- R10: A `start` pulse while `busy` is high is ignored. It adds no bus access and does not change the result.
- R11: `busy` rises in the cycle after an accepted start and stays high until `done`. `done` is a one-cycle pulse during which `busy` is low. `err` stays stable while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_addr | input | ADDR_W | Byte address of the first sector |
| sect_cnt | input | CNT_W | Number of sectors to erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 3 | Result: 0 ok, 1 rejected, 2 window closed, 3 device fault, 4 no effect, 5 poll timeout |
| fl_cs | output | 1 | Flash access strobe, one cycle per access |
| fl_we | output | 1 | 1 = write access, 0 = read access |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid in the cycle after a read strobe |

## Verification
Two of the engine's functions can meet in the same poll read: recognising completion and exhausting the poll budget. The bench provokes this with a status script that first shows bit 7 high on exactly the POLL_LIMIT-th read. It judges the outcome by requiring `err`=0 rather than 5. The count of poll reads seen at the bus must equal the limit.

A second overlap is a fresh `start` arriving while a request is running. It is judged by the bus log showing a single preamble and an unchanged result.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SECTOR,
        ST_WIN_READ,
        ST_WIN_WAIT,
        ST_POLL_READ,
        ST_POLL_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_REJECT   = 3'd1,
        RES_WINDOW   = 3'd2,
        RES_FAULT    = 3'd3,
        RES_NOEFFECT = 3'd4,
        RES_TIMEOUT  = 3'd5
    } seq_result_t;

    localparam int PREAMBLE_LEN = 6;
    localparam logic [7:0] SECTOR_CMD = 8'h30;

endpackage

// File: rtl/unlock_table.sv
module unlock_table
    import sector_erase_pkg::*;
(
    input  logic [2:0]  idx,
    output logic [11:0] cmd_addr,
    output logic [7:0]  cmd_data
);
    always_comb begin
        unique case (idx)
            3'd0:    begin cmd_addr = 12'h555; cmd_data = 8'hF0; end
            3'd1:    begin cmd_addr = 12'h555; cmd_data = 8'hAA; end
            3'd2:    begin cmd_addr = 12'h2AA; cmd_data = 8'h55; end
            3'd3:    begin cmd_addr = 12'h555; cmd_data = 8'h80; end
            3'd4:    begin cmd_addr = 12'h555; cmd_data = 8'hAA; end
            3'd5:    begin cmd_addr = 12'h2AA; cmd_data = 8'h55; end
            default: begin cmd_addr = 12'h000; cmd_data = 8'h00; end
        endcase
    end
endmodule

// File: rtl/poll_judge.sv
module poll_judge (
    input  logic [7:0] now_rd,
    input  logic [7:0] last_rd,
    input  logic [7:0] older_rd,
    output logic       finished,
    output logic       stalled,
    output logic       fault_flag
);
    always_comb begin
        finished   = now_rd[7];
        stalled    = !now_rd[7] && (now_rd == last_rd);
        fault_flag = older_rd[5];
    end
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import sector_erase_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int SECT_W     = 16,
    parameter int CNT_W      = ADDR_W - SECT_W + 1,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  sect_cnt,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err,
    output logic              fl_cs,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata
);
    localparam int IDX_W  = ADDR_W - SECT_W;
    localparam int SUM_W  = CNT_W + 1;
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [SUM_W-1:0] NUM_SECT = SUM_W'(1) << IDX_W;
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

    seq_state_t        state_q, state_d;
    seq_result_t       res_q;
    logic [IDX_W-1:0]  sect_q, base_q;
    logic [CNT_W-1:0]  left_q;
    logic              first_q;
    logic [2:0]        pre_idx_q;
    logic [POLL_W-1:0] nread_q;
    logic [7:0]        rd0_q, rd1_q;

    // request check
    logic [IDX_W-1:0] req_sect;
    logic             req_ok;
    always_comb begin
        req_sect = start_addr[ADDR_W-1:SECT_W];
        req_ok   = (start_addr[SECT_W-1:0] == '0) && (sect_cnt != '0)
                 && ((SUM_W'(req_sect) + SUM_W'(sect_cnt)) <= NUM_SECT);
    end

    logic [11:0] pre_addr;
    logic [7:0]  pre_data;
    unlock_table u_table (.idx(pre_idx_q), .cmd_addr(pre_addr), .cmd_data(pre_data));

    logic finished, stalled, fault_flag, enough, verdict, exhausted;
    poll_judge u_judge (
        .now_rd(fl_rdata), .last_rd(rd0_q), .older_rd(rd1_q),
        .finished(finished), .stalled(stalled), .fault_flag(fault_flag)
    );
    assign enough    = (nread_q >= POLL_W'(2));
    assign verdict   = enough && (finished || stalled);
    assign exhausted = (nread_q == POLL_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = req_ok ? ST_PREAMBLE : ST_FINISH;
            ST_PREAMBLE:  if (pre_idx_q == 3'(PREAMBLE_LEN - 1)) state_d = ST_SECTOR;
            ST_SECTOR:    state_d = first_q ? ((left_q == CNT_W'(1)) ? ST_POLL_READ : ST_SECTOR)
                                            : ST_WIN_READ;
            ST_WIN_READ:  state_d = ST_WIN_WAIT;
            ST_WIN_WAIT:  state_d = fl_rdata[3] ? ST_FINISH
                                  : ((left_q == '0) ? ST_POLL_READ : ST_SECTOR);
            ST_POLL_READ: state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: state_d = (verdict || exhausted) ? ST_FINISH : ST_POLL_READ;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= RES_OK;
            sect_q    <= '0;
            base_q    <= '0;
            left_q    <= '0;
            first_q   <= 1'b0;
            pre_idx_q <= '0;
            nread_q   <= '0;
            rd0_q     <= '0;
            rd1_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    res_q     <= req_ok ? RES_OK : RES_REJECT;
                    sect_q    <= req_sect;
                    base_q    <= req_sect;
                    left_q    <= sect_cnt;
                    first_q   <= 1'b1;
                    pre_idx_q <= '0;
                    nread_q   <= '0;
                    rd0_q     <= '0;
                    rd1_q     <= '0;
                end
                ST_PREAMBLE: pre_idx_q <= pre_idx_q + 3'd1;
                ST_SECTOR: begin
                    left_q  <= left_q - CNT_W'(1);
                    first_q <= 1'b0;
                    if (first_q && left_q != CNT_W'(1)) sect_q <= sect_q + IDX_W'(1);
                end
                ST_WIN_WAIT: begin
                    if (fl_rdata[3])        res_q  <= RES_WINDOW;
                    else if (left_q != '0)  sect_q <= sect_q + IDX_W'(1);
                end
                ST_POLL_WAIT: begin
                    rd0_q   <= fl_rdata;
                    rd1_q   <= rd0_q;
                    nread_q <= nread_q + POLL_W'(1);
                    if (verdict) begin
                        if (!finished) res_q <= fault_flag ? RES_FAULT : RES_NOEFFECT;
                    end else if (exhausted) begin
                        res_q <= RES_TIMEOUT;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fl_cs    = 1'b0;
        fl_we    = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        busy     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done     = (state_q == ST_FINISH);
        err      = res_q;
        unique case (state_q)
            ST_PREAMBLE: begin
                fl_cs = 1'b1; fl_we = 1'b1;
                fl_addr = ADDR_W'(pre_addr); fl_wdata = pre_data;
            end
            ST_SECTOR: begin
                fl_cs = 1'b1; fl_we = 1'b1;
                fl_addr = {sect_q, {SECT_W{1'b0}}}; fl_wdata = SECTOR_CMD;
            end
            ST_WIN_READ:  begin fl_cs = 1'b1; fl_addr = {sect_q, {SECT_W{1'b0}}}; end
            ST_POLL_READ: begin fl_cs = 1'b1; fl_addr = {base_q, {SECT_W{1'b0}}}; end
            default: ;
        endcase
    end
endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk #(
    parameter int ADDR_W = 21
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] err,
    input logic       fl_cs,
    input logic       fl_we,
    input logic [7:0] fl_wdata
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
    AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(err)); // R11
    AST_NO_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !fl_cs); // R2
    AST_WRITE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cs && fl_we) |-> (fl_wdata inside {8'hF0, 8'hAA, 8'h55, 8'h80, 8'h30})); // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R10
    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) err <= 3'd5); // R9
endmodule

bind sector_erase_seq sector_erase_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .fl_cs(fl_cs), .fl_we(fl_we), .fl_wdata(fl_wdata)
);

// File: tb/sector_erase_seq_test.sv
module sector_erase_seq_test;
    localparam int ADDR_W = 21;
    localparam int SECT_W = 16;
    localparam int CNT_W  = ADDR_W - SECT_W + 1;
    localparam int PLIM   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  sect_cnt = '0;
    logic busy, done, fl_cs, fl_we;
    logic [2:0] err;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0] fl_wdata;
    logic [7:0] fl_rdata = 8'h00;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sector_erase_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .sect_cnt(sect_cnt), .busy(busy), .done(done), .err(err),
        .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    // flash model
    logic [ADDR_W-1:0] poll_addr = '0;
    logic [7:0] win_val = 8'h00;
    logic [7:0] settle_val = 8'hFF;
    logic [7:0] fault_bit = 8'h00;
    int toggle_n = 4;
    int poll_reads = 0;
    int win_reads = 0;
    int nwr = 0;
    logic [ADDR_W-1:0] wr_addr [64];
    logic [7:0] wr_data [64];

    always @(posedge clk) begin
        if (fl_cs && fl_we) begin
            if (nwr < 64) begin wr_addr[nwr] <= fl_addr; wr_data[nwr] <= fl_wdata; end
            nwr <= nwr + 1;
        end else if (fl_cs) begin
            if (fl_addr == poll_addr) begin
                if (poll_reads + 1 > toggle_n) fl_rdata <= settle_val;
                else fl_rdata <= (((poll_reads + 1) % 2 == 1) ? 8'h40 : 8'h00) | fault_bit;
                poll_reads <= poll_reads + 1;
            end else begin
                fl_rdata <= win_val;
                win_reads <= win_reads + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model(input logic [ADDR_W-1:0] pa);
        @(negedge clk);
        poll_addr = pa; nwr = 0; poll_reads = 0; win_reads = 0;
    endtask

    task automatic run_op(input logic [ADDR_W-1:0] a, input int n, output int res, input bit poke);
        int guard;
        @(negedge clk);
        start_addr = a; sect_cnt = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start_addr = '0; sect_cnt = CNT_W'(1); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        res = err;
        check("R11 done not with busy", int'(busy), 0);
        @(negedge clk);
        check("R11 done one cycle", int'(done), 0);
    endtask

    task automatic check_preamble();
        check("R3 p0a", int'(wr_addr[0]), 'h555); check("R3 p0d", int'(wr_data[0]), 'hF0);
        check("R3 p1a", int'(wr_addr[1]), 'h555); check("R3 p1d", int'(wr_data[1]), 'hAA);
        check("R3 p2a", int'(wr_addr[2]), 'h2AA); check("R3 p2d", int'(wr_data[2]), 'h55);
        check("R3 p3a", int'(wr_addr[3]), 'h555); check("R3 p3d", int'(wr_data[3]), 'h80);
        check("R3 p4a", int'(wr_addr[4]), 'h555); check("R3 p4d", int'(wr_data[4]), 'hAA);
        check("R3 p5a", int'(wr_addr[5]), 'h2AA); check("R3 p5d", int'(wr_data[5]), 'h55);
    endtask

    task automatic test_reject();
        int res;
        clear_model('0);
        run_op(21'h01_0100, 1, res, 0);
        check("R2 misaligned err", res, 1);
        run_op(21'h02_0000, 0, res, 0);
        check("R2 zero count err", res, 1);
        run_op(21'h1E_0000, 3, res, 0);
        check("R2 overrun err", res, 1);
        check("R2 no writes", nwr, 0);
        check("R2 no reads", poll_reads + win_reads, 0);
    endtask

    task automatic test_normal();
        int res;
        clear_model(21'h1D_0000);
        win_val = 8'h00; toggle_n = 4; settle_val = 8'hFF; fault_bit = 8'h00;
        @(negedge clk);
        start_addr = 21'h1D_0000; sect_cnt = CNT_W'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after start", int'(busy), 1);
        while (!done) @(negedge clk);
        res = err;
        @(negedge clk);
        check("R6 err ok", res, 0);
        check("R4 write count", nwr, 9);
        check_preamble();
        for (int k = 0; k < 3; k++) begin
            check("R4 sector addr", int'(wr_addr[6+k]), 'h1D_0000 + k * 'h1_0000);
            check("R4 sector data", int'(wr_data[6+k]), 'h30);
        end
        check("R5 window reads", win_reads, 2);
        check("R6 poll reads", poll_reads, 5);
        @(negedge clk);
        check("R11 err held idle", int'(err), 0);
    endtask

    task automatic test_edge_fit();
        int res;
        clear_model(21'h1E_0000);
        win_val = 8'h00; toggle_n = 2; settle_val = 8'hFF; fault_bit = 8'h00;
        run_op(21'h1E_0000, 2, res, 0);
        check("R2 last sector fits", res, 0);
        check("R4 last addr", int'(wr_addr[7]), 'h1F_0000);
        check("R6 min poll reads", poll_reads, 3);
    endtask

    task automatic test_window();
        int res;
        clear_model(21'h04_0000);
        win_val = 8'h08; toggle_n = 4; settle_val = 8'hFF;
        run_op(21'h04_0000, 4, res, 0);
        check("R5 err window", res, 2);
        check("R5 writes stop", nwr, 8);
        check("R5 one window read", win_reads, 1);
        check("R5 no poll", poll_reads, 0);
        win_val = 8'h00;
    endtask

    task automatic test_stall(input logic [7:0] fb, input logic [7:0] sv, input int exp, input string req);
        int res;
        clear_model(21'h08_0000);
        toggle_n = 4; fault_bit = fb; settle_val = sv;
        run_op(21'h08_0000, 1, res, 0);
        check(req, res, exp);
        check(req, poll_reads, 5);
        check("R5 single sector no window read", win_reads, 0);
        fault_bit = 8'h00;
    endtask

    task automatic test_timeout();
        int res;
        clear_model(21'h00_0000);
        toggle_n = 100000; settle_val = 8'hFF;
        run_op(21'h00_0000, 1, res, 0);
        check("R9 err timeout", res, 5);
        check("R9 poll count", poll_reads, PLIM);
        clear_model(21'h00_0000);
        toggle_n = PLIM - 1;
        run_op(21'h00_0000, 1, res, 0);
        check("R9 completion on last read wins", res, 0);
        check("R9 last read count", poll_reads, PLIM);
    endtask

    task automatic test_busy_start();
        int res;
        clear_model(21'h10_0000);
        toggle_n = 4; settle_val = 8'hFF; win_val = 8'h00;
        run_op(21'h10_0000, 2, res, 1);
        check("R10 err unchanged", res, 0);
        check("R10 single preamble", nwr, 8);
        check("R10 first sector kept", int'(wr_addr[6]), 'h10_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 cs", int'(fl_cs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        test_reject();
        test_normal();
        test_edge_fit();
        test_window();
        test_stall(8'h20, 8'h20, 3, "R7 device fault");
        test_stall(8'h00, 8'h00, 4, "R8 no effect");
        test_timeout();
        test_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule